// File: doc/BRIEF.md
# Per-Lane Sampling Strobe Calibration Controller

This block chooses, for each lane of a multi-lane receiver, which oversampled phase of the incoming bit is used as that lane's data. Every lane supplies PHASES samples of its bit in each clock cycle. During a calibration window the block counts, for every phase position, how often the lane's bit changes value there. When the window closes, each lane's phase select points halfway round the phase circle from the position with the most changes. That position is the best estimate of the eye centre. Each lane is tuned on its own, over its own phase range.

Calibration waits for the PLL-lock input and then runs for exactly WIN_LEN clock cycles (4096 by default). While it runs, the busy flag is high and every data output is held at zero. A single calibration can be started again by holding the control input low for more than PULSE_MIN-1 cycles and then returning it high. Shorter low glitches are ignored. While the control input stays low, windows run back to back. The phase selects are refreshed at the end of each window, and the busy flag and zeroed outputs remain in force.

Top module: `deskew_cal_ctrl`

## Requirements
- R1: After reset the busy flag is 1, every phase select is 0 and every data output is 0.
- R2: No window starts while the lock input is low; the busy flag stays 1 while the block waits for lock.
- R3: A window accumulates exactly WIN_LEN input words. The busy flag falls on the (WIN_LEN+2)th rising edge, counting the first edge at which lock is sampled high as edge 1.
- R4: While the busy flag is 1, every data output is 0, whatever the input bits are.
- R5: An edge is counted at phase p when sample p of a lane word differs from sample p-1. Sample 0 is compared with sample PHASES-1 of the same word. At the end of the window the lane's select becomes (m + PHASES/2) mod PHASES, where m is the phase with the highest count.
- R6: When two or more phases share the highest count, m is the lowest-numbered of them.
- R7: The new phase selects appear on the same clock edge at which the busy flag falls.
- R8: A low period of the control input of PULSE_MIN-1 (4) cycles or fewer has no effect. The busy flag stays 0 and the phase selects keep their values.
- R9: A low period of PULSE_MIN (5) or more cycles, followed by a return high, starts a new calibration. The busy flag rises within 4 cycles of the return high.
- R10: While the control input is held low past PULSE_MIN cycles, the busy flag stays 1, windows repeat, and the phase selects are reloaded at the end of every window.
- R11: With the busy flag at 0, data output l equals sample phase_sel[l] of lane l's current word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe_ctl | input | 1 | Calibration control level; a long low period restarts calibration, and holding it low keeps calibration running |
| pll_locked | input | 1 | PLL lock indication; a window starts only once this is high |
| os_bits | input | LANES*PHASES | Oversampled bits; lane l occupies bits [l*PHASES +: PHASES], with sample 0 in the lowest bit |
| phase_sel | output | LANES*$clog2(PHASES) | Selected sampling phase per lane, packed the same way |
| lane_data | output | LANES | Per-lane sampled bit, forced to 0 while calibrating |
| cal_busy | output | 1 | High while waiting for lock or calibrating |

## Verification
The bench drives patterns that repeat every four cycles. Because of that, edge counts over any window are known exactly, and it sweeps many random patterns plus constructed ties. A design that broke ties toward the higher index, or that dropped the wrap-around compare at sample 0, would pick phases offset from the expected ones. A window that is one cycle too long or too short shifts the measured busy-fall edge. A pulse filter that is off by one either restarts on a four-cycle glitch, which the bench sees as a rise of the busy flag, or misses the five-cycle pulse. The held-low test changes the pattern and checks that the selects are refreshed while busy never drops and the data outputs stay at zero.

// File: rtl/dsk_pkg.sv
package dsk_pkg;

   typedef enum logic [1:0] {
      ST_WAIT = 2'd0,
      ST_RUN  = 2'd1,
      ST_DONE = 2'd2,
      ST_IDLE = 2'd3
   } dsk_state_e;

endpackage

// File: rtl/dsk_pulse_filter.sv
module dsk_pulse_filter #(
   parameter int unsigned LIM = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ctl_lvl,
   output logic low_long
);

   localparam int unsigned LW = $clog2(LIM + 1);

   logic [LW-1:0] lowcnt_q;

   // counts consecutive low samples, saturating at LIM
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         lowcnt_q <= '0;
      else if (ctl_lvl)
         lowcnt_q <= '0;
      else if (lowcnt_q != LW'(LIM))
         lowcnt_q <= lowcnt_q + 1'b1;
   end

   assign low_long = (lowcnt_q == LW'(LIM));

   // R8
   lowcnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lowcnt_q <= LW'(LIM));

   // R8
   short_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_lvl |=> (lowcnt_q == '0));

endmodule

// File: rtl/dsk_seq.sv
module dsk_seq
   import dsk_pkg::*;
#(
   parameter int unsigned WIN_LEN = 4096
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pll_locked,
   input  logic ctl_lvl,
   input  logic low_long,
   output logic clr,
   output logic acc,
   output logic load,
   output logic busy
);

   localparam int unsigned WW = (WIN_LEN > 2) ? $clog2(WIN_LEN) : 1;
   localparam logic [WW-1:0] LAST = WW'(WIN_LEN - 1);

   dsk_state_e    state_q, state_d;
   logic [WW-1:0] wcnt_q;
   logic          busy_q, busy_d;

   always_comb begin
      state_d = state_q;
      busy_d  = busy_q;
      unique case (state_q)
         ST_WAIT: begin
            busy_d = 1'b1;
            if (pll_locked)
               state_d = ST_RUN;
         end
         ST_RUN: begin
            busy_d = 1'b1;
            if (low_long && ctl_lvl)
               state_d = ST_WAIT;
            else if (wcnt_q == LAST)
               state_d = ST_DONE;
         end
         ST_DONE: begin
            if (low_long) begin
               state_d = ST_WAIT;
               busy_d  = 1'b1;
            end else begin
               state_d = ST_IDLE;
               busy_d  = 1'b0;
            end
         end
         ST_IDLE: begin
            if (low_long) begin
               state_d = ST_WAIT;
               busy_d  = 1'b1;
            end else begin
               busy_d  = 1'b0;
            end
         end
         default: begin
            state_d = ST_WAIT;
            busy_d  = 1'b1;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_WAIT;
         busy_q  <= 1'b1;
         wcnt_q  <= '0;
      end else begin
         state_q <= state_d;
         busy_q  <= busy_d;
         if (state_q == ST_RUN && state_d == ST_RUN)
            wcnt_q <= wcnt_q + 1'b1;
         else
            wcnt_q <= '0;
      end
   end

   assign clr  = (state_q == ST_WAIT);
   assign acc  = (state_q == ST_RUN);
   assign load = (state_q == ST_DONE);
   assign busy = busy_q;

   // R3
   wcnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_RUN) |-> (wcnt_q == '0));

   // R7
   busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_q) |-> ($past(state_q) == ST_DONE));

   // R2
   lock_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_WAIT && !pll_locked) |=> (state_q == ST_WAIT && busy_q));

endmodule

// File: rtl/dsk_edge_tally.sv
module dsk_edge_tally #(
   parameter int unsigned PHASES  = 8,
   parameter int unsigned WIN_LEN = 4096
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        clr,
   input  logic                        acc,
   input  logic                        load,
   input  logic [PHASES-1:0]           os_word,
   output logic [$clog2(PHASES)-1:0]   phase_sel
);

   localparam int unsigned CW   = $clog2(WIN_LEN + 1);
   localparam int unsigned PSW  = $clog2(PHASES);
   localparam int unsigned HALF = PHASES / 2;

   logic [PHASES-1:0] edge_v;
   logic [CW-1:0]     cnt_q [PHASES];
   logic [PSW-1:0]    best_idx;
   logic [CW-1:0]     best_cnt;
   logic [PSW-1:0]    phase_q;

   for (genvar p = 0; p < PHASES; p++) begin : g_phase
      // change between sample p-1 and sample p, wrapping inside the word
      assign edge_v[p] = os_word[p] ^ os_word[(p + PHASES - 1) % PHASES];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cnt_q[p] <= '0;
         else if (clr)
            cnt_q[p] <= '0;
         else if (acc && edge_v[p])
            cnt_q[p] <= cnt_q[p] + 1'b1;
      end

      // R5
      cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
         cnt_q[p] <= CW'(WIN_LEN));
   end

   // strict compare keeps the lowest index on ties
   always_comb begin
      best_idx = '0;
      best_cnt = cnt_q[0];
      for (int i = 1; i < PHASES; i++) begin
         if (cnt_q[i] > best_cnt) begin
            best_cnt = cnt_q[i];
            best_idx = PSW'(i);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         phase_q <= '0;
      else if (load)
         phase_q <= best_idx + PSW'(HALF);
   end

   assign phase_sel = phase_q;

   // R10
   sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(load) |-> $stable(phase_q));

endmodule

// File: rtl/deskew_cal_ctrl.sv
module deskew_cal_ctrl
   import dsk_pkg::*;
#(
   parameter int unsigned LANES     = 4,
   parameter int unsigned PHASES    = 8,
   parameter int unsigned WIN_LEN   = 4096,
   parameter int unsigned PULSE_MIN = 5
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              strobe_ctl,
   input  logic                              pll_locked,
   input  logic [LANES*PHASES-1:0]           os_bits,
   output logic [LANES*$clog2(PHASES)-1:0]   phase_sel,
   output logic [LANES-1:0]                  lane_data,
   output logic                              cal_busy
);

   localparam int unsigned PSW = $clog2(PHASES);

   if (PHASES < 4 || (PHASES & (PHASES - 1)) != 0) begin : g_bad_phases
      $error("PHASES must be a power of two of at least 4");
   end
   if (LANES < 1) begin : g_bad_lanes
      $error("LANES must be at least 1");
   end
   if (WIN_LEN < 2) begin : g_bad_win
      $error("WIN_LEN must be at least 2");
   end
   if (PULSE_MIN < 1) begin : g_bad_pulse
      $error("PULSE_MIN must be at least 1");
   end

   logic low_long;
   logic clr, acc, load, busy;

   dsk_pulse_filter #(.LIM(PULSE_MIN)) u_filter (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctl_lvl  (strobe_ctl),
      .low_long (low_long)
   );

   dsk_seq #(.WIN_LEN(WIN_LEN)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .pll_locked (pll_locked),
      .ctl_lvl    (strobe_ctl),
      .low_long   (low_long),
      .clr        (clr),
      .acc        (acc),
      .load       (load),
      .busy       (busy)
   );

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [PHASES-1:0] word;
      logic [PSW-1:0]    sel;

      assign word = os_bits[l*PHASES +: PHASES];

      dsk_edge_tally #(.PHASES(PHASES), .WIN_LEN(WIN_LEN)) u_tally (
         .clk       (clk),
         .rst_n     (rst_n),
         .clr       (clr),
         .acc       (acc),
         .load      (load),
         .os_word   (word),
         .phase_sel (sel)
      );

      assign phase_sel[l*PSW +: PSW] = sel;
      assign lane_data[l] = busy ? 1'b0 : word[sel];
   end

   assign cal_busy = busy;

   // R8
   short_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cal_busy && !low_long) |=> !cal_busy);

   // R10
   held_low_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(low_long) |-> cal_busy);

endmodule

// File: tb/deskew_cal_ctrl_bench.sv
module deskew_cal_ctrl_bench;

   localparam int L   = 4;
   localparam int P   = 8;
   localparam int W   = 64;
   localparam int PM  = 5;
   localparam int PSW = 3;
   localparam int PER = 4;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic             rst_n;
   logic             strobe_ctl;
   logic             pll_locked;
   logic [L*P-1:0]   os_bits;
   logic [L*PSW-1:0] phase_sel;
   logic [L-1:0]     lane_data;
   logic             cal_busy;

   int n_run = 0;
   int n_fail = 0;
   int data_bad = 0;
   int short_bad = 0;
   int hold_bad = 0;
   bit watch_short = 1'b0;
   bit watch_hold = 1'b0;

   logic [P-1:0] pat [L][PER];
   int slot = 0;

   deskew_cal_ctrl #(.LANES(L), .PHASES(P), .WIN_LEN(W), .PULSE_MIN(PM)) u_deskew_cal_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .strobe_ctl (strobe_ctl),
      .pll_locked (pll_locked),
      .os_bits    (os_bits),
      .phase_sel  (phase_sel),
      .lane_data  (lane_data),
      .cal_busy   (cal_busy)
   );

   always @(negedge clk) slot = (slot + 1) % PER;

   always_comb begin
      for (int l = 0; l < L; l++) os_bits[l*P +: P] = pat[l][slot];
   end

   always @(posedge clk) begin
      #2;
      if (rst_n && cal_busy && lane_data != '0) data_bad++;
      if (watch_short && cal_busy) short_bad++;
      if (watch_hold && !cal_busy) hold_bad++;
   end

   function automatic int exp_sel(int l);
      int cnt [P];
      int m;
      for (int p = 0; p < P; p++) cnt[p] = 0;
      for (int s = 0; s < PER; s++)
         for (int p = 0; p < P; p++)
            if (pat[l][s][p] != pat[l][s][(p + P - 1) % P]) cnt[p]++;
      m = 0;
      for (int p = 1; p < P; p++) if (cnt[p] > cnt[m]) m = p;
      return (m + P/2) % P;
   endfunction

   task automatic chk(string req, int act, int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic check_cal(string req);
      for (int l = 0; l < L; l++) begin
         chk(req, int'(phase_sel[l*PSW +: PSW]), exp_sel(l));
         // R11 data follows the selected sample
         chk("R11", int'(lane_data[l]), int'(os_bits[l*P + exp_sel(l)]));
      end
   endtask

   task automatic new_pat();
      for (int l = 0; l < L; l++)
         for (int s = 0; s < PER; s++) pat[l][s] = P'($urandom);
   endtask

   task automatic wait_busy(logic lvl, int lim, output int n);
      n = 0;
      while (cal_busy !== lvl && n < lim) begin
         @(posedge clk); #2;
         n++;
      end
   endtask

   task automatic pulse_low(int k);
      @(negedge clk) strobe_ctl = 1'b0;
      repeat (k) @(negedge clk);
      strobe_ctl = 1'b1;
   endtask

   task automatic summary();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      int n;
      logic [L*PSW-1:0] saved;
      rst_n = 1'b0;
      strobe_ctl = 1'b1;
      pll_locked = 1'b0;
      // tie patterns: 0x01 -> edges 0,1; 0x80 -> edges 7,0; 0x00 -> none; 0x38 -> edges 3,6
      for (int s = 0; s < PER; s++) begin
         pat[0][s] = 8'h01; pat[1][s] = 8'h80; pat[2][s] = 8'h00; pat[3][s] = 8'h38;
      end
      repeat (3) @(posedge clk); #2;
      chk("R1 busy", int'(cal_busy), 1);
      chk("R1 sel", int'(phase_sel), 0);
      chk("R1 data", int'(lane_data), 0);
      @(negedge clk) rst_n = 1'b1;
      repeat (40) @(posedge clk); #2;
      chk("R2 busy while unlocked", int'(cal_busy), 1);
      chk("R2 sel unchanged", int'(phase_sel), 0);

      @(negedge clk) pll_locked = 1'b1;
      n = 0;
      do begin
         @(posedge clk); #2;
         n++;
      end while (cal_busy && n < 500);
      chk("R3 busy fall edge", n, W + 2);
      // R7 selects valid at the busy fall; R6 ties resolve low
      check_cal("R6");
      chk("R6 lane3", int'(phase_sel[3*PSW +: PSW]), 7);

      // exactly PULSE_MIN low cycles restarts
      new_pat();
      pulse_low(PM);
      wait_busy(1'b1, 4, n);
      chk("R9 busy rises", int'(cal_busy), 1);
      wait_busy(1'b0, W + 20, n);
      chk("R9 busy falls", int'(cal_busy), 0);
      check_cal("R5");

      for (int t = 0; t < 30; t++) begin
         new_pat();
         if (t % 5 == 0) for (int s = 1; s < PER; s++) pat[t % L][s] = pat[t % L][0];
         pulse_low(PM + (t % 4));
         wait_busy(1'b1, 4, n);
         chk("R9 restart", int'(cal_busy), 1);
         wait_busy(1'b0, W + 20, n);
         check_cal("R5");
      end

      // short pulses ignored
      saved = phase_sel;
      new_pat();
      watch_short = 1'b1;
      pulse_low(PM - 1);
      repeat (W + 10) @(posedge clk);
      pulse_low(1);
      repeat (20) @(posedge clk);
      #2;
      watch_short = 1'b0;
      chk("R8 busy stayed low", short_bad, 0);
      chk("R8 sel kept", int'(phase_sel), int'(saved));

      // held low: repeated windows, selects refresh, busy stays high
      new_pat();
      @(negedge clk) strobe_ctl = 1'b0;
      repeat (10) @(posedge clk);
      watch_hold = 1'b1;
      repeat (3 * (W + 4)) @(posedge clk);
      #2;
      chk("R10 busy held", int'(cal_busy), 1);
      for (int l = 0; l < L; l++)
         chk("R10 sel refreshed", int'(phase_sel[l*PSW +: PSW]), exp_sel(l));
      watch_hold = 1'b0;
      chk("R10 busy never dropped", hold_bad, 0);
      @(negedge clk) strobe_ctl = 1'b1;
      wait_busy(1'b0, W + 20, n);
      chk("R9 release", int'(cal_busy), 0);
      check_cal("R9");

      chk("R4 data low while busy", data_bad, 0);
      summary();
      $finish;
   end

endmodule